// File: doc/BRIEF.md
# Dual-Rail and One-Hot Quaternary Code Converters

This block joins two kinds of switching-balanced, return-to-zero code inside one datapath. In the combining direction, each lane takes two dual-rail binary digits, a high bit and a low bit, and presents the 2-bit value they form as a single 1-of-4 quaternary digit. In the separating direction, each lane takes one 1-of-4 digit and gives back its two bits as dual-rail digits. In both directions the all-low spacer passes through as an all-low spacer. The number of lanes is set by a parameter.

The converters themselves are combinational. The combining side keeps a small per-lane register so that a lane holds its last output while its two inputs arrive or return to spacer at different times. A registered completion detector on each converter output reports whether the whole output word holds data or spacer. A registered protocol monitor on each converter input reports two faults: a codeword that cannot occur, and a digit that moves from one data value to another without passing through spacer.

Top module: `rail_code_bridge`

## Requirements
- R1: Dual-rail digits use rails {true,false}: 2'b01 is logic 0, 2'b10 is logic 1, 2'b00 is spacer. A combining lane occupies bits [4k+3:4k] of the dual-rail bus, with the high digit in [4k+3:4k+2] and the low digit in [4k+1:4k]. When both digits of a lane hold data, the lane's 1-of-4 output in the same bits has exactly bit v set, where v = 2*high + low. This appears in the same cycle.
- R2: When both dual-rail digits of a combining lane are spacer, that lane's quaternary output is 4'b0000 in the same cycle.
- R3: In any other input state of a combining lane (one digit data and one spacer, or any 2'b11 digit), the output keeps the value it had in the previous cycle. This means a half-arrived word leaves the spacer in place, and a half-returned word keeps its data.
- R4: A separating lane whose 1-of-4 input has exactly bit v set outputs high digit = bit 1 of v and low digit = bit 0 of v, both in dual-rail code, in the same cycle.
- R5: A separating lane whose input is 4'b0000, or has more than one bit set, outputs spacer on both digits.
- R6: One cycle after the clock edge, mix_valid_o shows whether every lane of mix_q_o had exactly one bit set at that edge. spl_valid_o shows whether every dual-rail digit of spl_dr_o had exactly one bit set.
- R7: One cycle after the clock edge, mix_spacer_o shows whether mix_q_o was all zero at that edge, and spl_spacer_o shows whether spl_dr_o was all zero.
- R8: mix_err_o is set in the cycle after an edge at which any dual-rail input digit was 2'b11.
- R9: The error flag of a direction is set in the cycle after an edge at which one of its input digits held data different from the data it held at the previous edge. This covers mix_err_o for the dual-rail digits and spl_err_o for the 1-of-4 digits.
- R10: spl_err_o is set in the cycle after an edge at which any 1-of-4 input lane had more than one bit set. Otherwise, unless R9 applies, both error flags read 0.
- R11: While rst_n is low, all six status flags read 0 and every combining lane's held output is cleared, so a half-arrived input shows spacer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for held outputs and status flags |
| rst_n | input | 1 | Active-low synchronous reset |
| mix_dr_i | input | 4*NLANE (8) | Dual-rail pairs to combine, two digits per lane |
| mix_q_o | output | 4*NLANE (8) | 1-of-4 digits produced by combining, one per lane |
| spl_q_i | input | 4*NLANE (8) | 1-of-4 digits to separate, one per lane |
| spl_dr_o | output | 4*NLANE (8) | Dual-rail pairs produced by separating |
| mix_valid_o | output | 1 | Registered: combined output is complete data |
| mix_spacer_o | output | 1 | Registered: combined output is all spacer |
| mix_err_o | output | 1 | Registered: illegal or spacer-skipping dual-rail input |
| spl_valid_o | output | 1 | Registered: separated output is complete data |
| spl_spacer_o | output | 1 | Registered: separated output is all spacer |
| spl_err_o | output | 1 | Registered: illegal or spacer-skipping 1-of-4 input |

## Verification
Both converter outputs are due in the same cycle as their inputs. The bench changes inputs on the falling edge and reads mix_q_o and spl_dr_o 2 ns later. All six flags are due one rising edge after the inputs they describe. The bench therefore reads them 2 ns after that edge, while the inputs are still held, and its model of the previous input and the held lane output moves forward exactly once per step.

// File: rtl/rcb_pkg.sv
package rcb_pkg;

  localparam logic [1:0] DR_NULL = 2'b00;
  localparam logic [1:0] DR_LO   = 2'b01;
  localparam logic [1:0] DR_HI   = 2'b10;

  function automatic logic dr_is_data(input logic [1:0] d);
    return (d == DR_LO) || (d == DR_HI);
  endfunction

  function automatic logic [1:0] dr_of_bit(input logic b);
    return b ? DR_HI : DR_LO;
  endfunction

  // value formed by a high and a low dual-rail digit, as a 1-of-4 code
  function automatic logic [3:0] mix_code(input logic [1:0] hi, input logic [1:0] lo);
    logic [1:0] v;
    v = {hi == DR_HI, lo == DR_HI};
    return 4'b0001 << v;
  endfunction

  // index of the set bit of a one-hot 4-bit code
  function automatic logic [1:0] q_index(input logic [3:0] q);
    logic [1:0] v;
    unique case (q)
      4'b0010: v = 2'd1;
      4'b0100: v = 2'd2;
      4'b1000: v = 2'd3;
      default: v = 2'd0;
    endcase
    return v;
  endfunction

endpackage

// File: rtl/rcb_digit_mon.sv
module rcb_digit_mon #(
  parameter int W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] dig_i,
  output logic         illegal_o,
  output logic         skip_o
);

  logic [W-1:0] prev_q;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= dig_i;
  end

  always_comb begin
    illegal_o = ($countones(dig_i) > 1);
    skip_o    = $onehot(prev_q) && $onehot(dig_i) && (prev_q != dig_i);
  end

  // R9: a reported skip always coincides with a changed digit
  p_skip_changed_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && skip_o) |-> !$stable(dig_i));

endmodule

// File: rtl/rcb_done.sv
module rcb_done #(
  parameter int NDIG = 2,
  parameter int W    = 4
) (
  input  logic [NDIG*W-1:0] word_i,
  output logic              all_data_o,
  output logic              all_null_o
);

  logic [NDIG-1:0] dig_ok;

  for (genvar g = 0; g < NDIG; g++) begin : g_dig
    assign dig_ok[g] = $onehot(word_i[g*W +: W]);
  end

  assign all_data_o = &dig_ok;
  assign all_null_o = (word_i == '0);

endmodule

// File: rtl/rcb_mixer_lane.sv
module rcb_mixer_lane
  import rcb_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] hi_i,
  input  logic [1:0] lo_i,
  output logic [3:0] q_o
);

  logic       both_data;
  logic       both_null;
  logic [3:0] held_q;

  always_comb begin
    both_data = dr_is_data(hi_i) && dr_is_data(lo_i);
    both_null = (hi_i == DR_NULL) && (lo_i == DR_NULL);
    if (both_data)      q_o = mix_code(hi_i, lo_i);
    else if (both_null) q_o = '0;
    else                q_o = held_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= q_o;
  end

  p_mix_onehot_r1: assert property (@(posedge clk) disable iff (!rst_n)
    both_data |-> $onehot(q_o));

  p_mix_null_r2: assert property (@(posedge clk) disable iff (!rst_n)
    both_null |-> (q_o == 4'b0000));

  p_mix_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !both_data && !both_null) |-> (q_o == $past(q_o)));

endmodule

// File: rtl/rcb_splitter_lane.sv
module rcb_splitter_lane
  import rcb_pkg::*;
(
  input  logic [3:0] q_i,
  output logic [1:0] hi_o,
  output logic [1:0] lo_o
);

  logic [1:0] v;

  always_comb begin
    v = q_index(q_i);
    if ($onehot(q_i)) begin
      hi_o = dr_of_bit(v[1]);
      lo_o = dr_of_bit(v[0]);
    end else begin
      hi_o = DR_NULL;
      lo_o = DR_NULL;
    end
  end

  always_comb begin
    p_spl_data_r4: assert ($isunknown(q_i) || !$onehot(q_i) ||
                           ($onehot(hi_o) && $onehot(lo_o)));
    p_spl_null_r5: assert ($isunknown(q_i) || $onehot(q_i) ||
                           ((hi_o == DR_NULL) && (lo_o == DR_NULL)));
  end

endmodule

// File: rtl/rail_code_bridge.sv
module rail_code_bridge #(
  parameter int NLANE = 2
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [4*NLANE-1:0] mix_dr_i,
  output logic [4*NLANE-1:0] mix_q_o,
  input  logic [4*NLANE-1:0] spl_q_i,
  output logic [4*NLANE-1:0] spl_dr_o,
  output logic               mix_valid_o,
  output logic               mix_spacer_o,
  output logic               mix_err_o,
  output logic               spl_valid_o,
  output logic               spl_spacer_o,
  output logic               spl_err_o
);

  localparam int NDR = 2 * NLANE;

  logic [NDR-1:0]   dr_illegal, dr_skip;
  logic [NLANE-1:0] q_illegal, q_skip;
  logic             mix_done, mix_null, spl_done, spl_null;
  logic             mix_fault, spl_fault;

  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    rcb_mixer_lane u_mix (
      .clk   (clk),
      .rst_n (rst_n),
      .hi_i  (mix_dr_i[4*k+2 +: 2]),
      .lo_i  (mix_dr_i[4*k   +: 2]),
      .q_o   (mix_q_o[4*k +: 4])
    );

    rcb_splitter_lane u_spl (
      .q_i  (spl_q_i[4*k +: 4]),
      .hi_o (spl_dr_o[4*k+2 +: 2]),
      .lo_o (spl_dr_o[4*k   +: 2])
    );

    rcb_digit_mon #(.W(4)) u_qmon (
      .clk       (clk),
      .rst_n     (rst_n),
      .dig_i     (spl_q_i[4*k +: 4]),
      .illegal_o (q_illegal[k]),
      .skip_o    (q_skip[k])
    );
  end

  for (genvar d = 0; d < NDR; d++) begin : g_drmon
    rcb_digit_mon #(.W(2)) u_drmon (
      .clk       (clk),
      .rst_n     (rst_n),
      .dig_i     (mix_dr_i[2*d +: 2]),
      .illegal_o (dr_illegal[d]),
      .skip_o    (dr_skip[d])
    );
  end

  rcb_done #(.NDIG(NLANE), .W(4)) u_mix_done (
    .word_i     (mix_q_o),
    .all_data_o (mix_done),
    .all_null_o (mix_null)
  );

  rcb_done #(.NDIG(NDR), .W(2)) u_spl_done (
    .word_i     (spl_dr_o),
    .all_data_o (spl_done),
    .all_null_o (spl_null)
  );

  assign mix_fault = (|dr_illegal) || (|dr_skip);
  assign spl_fault = (|q_illegal)  || (|q_skip);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mix_valid_o  <= 1'b0;
      mix_spacer_o <= 1'b0;
      mix_err_o    <= 1'b0;
      spl_valid_o  <= 1'b0;
      spl_spacer_o <= 1'b0;
      spl_err_o    <= 1'b0;
    end else begin
      mix_valid_o  <= mix_done;
      mix_spacer_o <= mix_null;
      mix_err_o    <= mix_fault;
      spl_valid_o  <= spl_done;
      spl_spacer_o <= spl_null;
      spl_err_o    <= spl_fault;
    end
  end

  p_flags_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(mix_valid_o && mix_spacer_o) && !(spl_valid_o && spl_spacer_o));

  p_spacer_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (mix_q_o == '0) |=> mix_spacer_o);

  p_mix_err_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|dr_illegal) |=> mix_err_o);

  p_spl_err_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (|q_illegal) |=> spl_err_o);

  p_reset_flags_r11: assert property (@(posedge clk)
    $past(!rst_n) |-> !(mix_valid_o || mix_spacer_o || mix_err_o ||
                        spl_valid_o || spl_spacer_o || spl_err_o));

endmodule

// File: tb/rail_code_bridge_bench.sv
module rail_code_bridge_bench;

  localparam int NL = 2;
  localparam int BW = 4 * NL;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic [BW-1:0] dr_drv = '0;
  logic [BW-1:0] q_drv = '0;
  logic          loop_sel = 1'b1;
  logic [BW-1:0] mix_q, spl_in, spl_dr;
  logic          mv, ms, me, sv, ss, se;

  int checks = 0;
  int fails  = 0;

  logic [BW-1:0] m_held = '0;
  logic [BW-1:0] m_prev_dr = '0;
  logic [BW-1:0] m_prev_q = '0;

  always #10 clk = ~clk;

  assign spl_in = loop_sel ? mix_q : q_drv;

  rail_code_bridge #(.NLANE(NL)) u_rail_code_bridge (
    .clk (clk), .rst_n (rst_n),
    .mix_dr_i (dr_drv), .mix_q_o (mix_q),
    .spl_q_i (spl_in), .spl_dr_o (spl_dr),
    .mix_valid_o (mv), .mix_spacer_o (ms), .mix_err_o (me),
    .spl_valid_o (sv), .spl_spacer_o (ss), .spl_err_o (se)
  );

  function automatic logic isd(input logic [1:0] d);
    return d[0] ^ d[1];
  endfunction

  function automatic int ones(input logic [3:0] x);
    int n = 0;
    for (int i = 0; i < 4; i++) n += int'(x[i]);
    return n;
  endfunction

  function automatic logic [3:0] lane_q(input logic [1:0] h, input logic [1:0] l,
                                        input logic [3:0] held);
    if (isd(h) && isd(l)) return 4'd1 << {h[1], l[1]};
    if (h == 2'b00 && l == 2'b00) return 4'd0;
    return held;
  endfunction

  function automatic logic [3:0] lane_split(input logic [3:0] q);
    logic hb, lb;
    if (ones(q) != 1) return 4'd0;
    hb = q[3] | q[2];
    lb = q[3] | q[1];
    return {hb ? 2'b10 : 2'b01, lb ? 2'b10 : 2'b01};
  endfunction

  function automatic logic [BW-1:0] dr_word(input int v0, input int v1);
    logic [BW-1:0] w;
    w[1:0] = v0[0] ? 2'b10 : 2'b01;
    w[3:2] = v0[1] ? 2'b10 : 2'b01;
    w[5:4] = v1[0] ? 2'b10 : 2'b01;
    w[7:6] = v1[1] ? 2'b10 : 2'b01;
    return w;
  endfunction

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %b expected %b", tag, act, exp);
    end
  endtask

  task automatic step(input logic [BW-1:0] dr, input logic [BW-1:0] qd, input logic sel);
    logic [BW-1:0] eq, qs, es;
    logic emv, ems, eme, esv, ess, ese, any11, anyq;
    @(negedge clk);
    dr_drv = dr; q_drv = qd; loop_sel = sel;
    #2;
    for (int k = 0; k < NL; k++)
      eq[4*k +: 4] = lane_q(dr[4*k+2 +: 2], dr[4*k +: 2], m_held[4*k +: 4]);
    qs = sel ? eq : qd;
    for (int k = 0; k < NL; k++) es[4*k +: 4] = lane_split(qs[4*k +: 4]);
    for (int k = 0; k < NL; k++) begin
      logic [1:0] h, l;
      h = dr[4*k+2 +: 2]; l = dr[4*k +: 2];
      if (isd(h) && isd(l))       chk("R1 mix lane", {4'd0, mix_q[4*k +: 4]}, {4'd0, eq[4*k +: 4]});
      else if (h == 0 && l == 0)  chk("R2 mix lane", {4'd0, mix_q[4*k +: 4]}, {4'd0, eq[4*k +: 4]});
      else                        chk("R3 mix lane", {4'd0, mix_q[4*k +: 4]}, {4'd0, eq[4*k +: 4]});
      if (ones(qs[4*k +: 4]) == 1) chk("R4 split lane", {4'd0, spl_dr[4*k +: 4]}, {4'd0, es[4*k +: 4]});
      else                         chk("R5 split lane", {4'd0, spl_dr[4*k +: 4]}, {4'd0, es[4*k +: 4]});
    end
    emv = 1'b1; esv = 1'b1; any11 = 1'b0; anyq = 1'b0; eme = 1'b0; ese = 1'b0;
    for (int k = 0; k < NL; k++) begin
      if (ones(eq[4*k +: 4]) != 1) emv = 1'b0;
      if (es[4*k +: 4] == 0) esv = 1'b0;
      if (ones(qs[4*k +: 4]) > 1) anyq = 1'b1;
      if (ones(m_prev_q[4*k +: 4]) == 1 && ones(qs[4*k +: 4]) == 1 &&
          m_prev_q[4*k +: 4] != qs[4*k +: 4]) ese = 1'b1;
    end
    for (int d = 0; d < 2*NL; d++) begin
      if (dr[2*d +: 2] == 2'b11) any11 = 1'b1;
      if (isd(m_prev_dr[2*d +: 2]) && isd(dr[2*d +: 2]) &&
          m_prev_dr[2*d +: 2] != dr[2*d +: 2]) eme = 1'b1;
    end
    eme = eme | any11;
    ese = ese | anyq;
    ems = (eq == 0);
    ess = (es == 0);
    @(posedge clk);
    #2;
    chk("R6 mix_valid", {7'd0, mv}, {7'd0, emv});
    chk("R6 spl_valid", {7'd0, sv}, {7'd0, esv});
    chk("R7 mix_spacer", {7'd0, ms}, {7'd0, ems});
    chk("R7 spl_spacer", {7'd0, ss}, {7'd0, ess});
    if (any11) chk("R8 mix_err", {7'd0, me}, {7'd0, eme});
    else       chk("R9 mix_err", {7'd0, me}, {7'd0, eme});
    if (anyq)  chk("R10 spl_err", {7'd0, se}, {7'd0, ese});
    else       chk("R9 spl_err", {7'd0, se}, {7'd0, ese});
    m_held = eq; m_prev_dr = dr; m_prev_q = qs;
  endtask

  function automatic logic [1:0] rnd_dr();
    int r = $urandom_range(0, 9);
    if (r < 4) return 2'b00;
    if (r < 9) return ($urandom_range(0, 1) != 0) ? 2'b10 : 2'b01;
    return 2'b11;
  endfunction

  function automatic logic [3:0] rnd_q();
    int r = $urandom_range(0, 9);
    if (r < 4) return 4'd0;
    if (r < 9) return 4'd1 << $urandom_range(0, 3);
    return 4'($urandom_range(0, 15));
  endfunction

  initial begin
    #(20 * 150000);
    fails++;
    checks++;
    $display("FAIL watchdog: actual hung expected done");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int seed;
    seed = $urandom(32'd4711);
    // R11: half-arrived input during reset shows spacer, flags low
    dr_drv = 8'h08;
    repeat (3) @(posedge clk);
    #2;
    chk("R11 mix_q in reset", mix_q, 8'h00);
    chk("R11 flags in reset", {2'b00, mv, ms, me, sv, ss, se}, 8'h00);
    @(negedge clk);
    dr_drv = '0;
    @(negedge clk);
    rst_n = 1'b1;

    // R1/R4: all 16 lane value pairs, round trip with spacers between
    for (int a = 0; a < 4; a++)
      for (int b = 0; b < 4; b++) begin
        step(dr_word(a, b), '0, 1'b1);
        step('0, '0, 1'b1);
      end

    // R3: staggered arrival and return on lane 0
    step(8'h08, '0, 1'b1);
    step(8'h09, '0, 1'b1);
    step(8'h01, '0, 1'b1);
    step(8'h00, '0, 1'b1);

    // R8: 2'b11 on a low digit
    step(8'h03, '0, 1'b1);
    step(8'h00, '0, 1'b1);

    // R9: dual-rail data to data without spacer
    step(dr_word(1, 2), '0, 1'b1);
    step(dr_word(2, 2), '0, 1'b1);
    step(8'h00, '0, 1'b1);

    // R10/R5: multi-hot quaternary input; R9 quaternary skip
    step('0, 8'h03, 1'b0);
    step('0, 8'h00, 1'b0);
    step('0, 8'h12, 1'b0);
    step('0, 8'h14, 1'b0);
    step('0, 8'h00, 1'b0);

    // mixed random traffic
    for (int n = 0; n < 400; n++) begin
      logic [BW-1:0] rd, rq;
      for (int d = 0; d < 2*NL; d++) rd[2*d +: 2] = rnd_dr();
      for (int k = 0; k < NL; k++)   rq[4*k +: 4] = rnd_q();
      step(rd, rq, $urandom_range(0, 1) != 0);
    end

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule